// File: doc/BRIEF.md
# SPI FPGA Configuration Load Sequencer

This block brings up an SRAM-based FPGA that takes its configuration as an SPI slave. It runs the whole power-up and bitstream load from the host side. On a start pulse it holds the target in reset and pulls chip select low. Only then does it switch on the I/O and core supply enables and wait the power-up settling time. After that it releases chip select briefly and lowers it again to stream the configuration bytes. The bytes are shifted out as an SPI master in mode 0, most significant bit first. A fixed run of dummy clocks follows the bitstream, and the block then watches the target's configuration-done pin within a timeout.

Configuration bytes arrive on a ready/valid byte port, with a flag that marks the final byte. All delays are counted in system clock cycles derived from the `CLK_HZ` parameter. The SPI clock divider comes from the same parameter, so the serial clock never exceeds the configured maximum. The outcome appears on a `done` or an `error` output. The target stays in reset afterwards, and some later agent releases it.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After system reset `tgt_rst_n` is 1. It goes to 0 in the cycle after a start is accepted and stays 0 through the DONE and ERROR outcomes.
- R2: Chip select (`tgt_cs_n`, active low) is low for exactly `CS_LEAD_US` microseconds (default 1) before the supply enables rise. `sclk` has no rising edge in that window.
- R3: `vio_en` and `vcore_en` rise in the same cycle. Both stay 1 while `done` or `error` is 1.
- R4: `tgt_cs_n` returns to 1 exactly `POWER_US` microseconds (default 50) after the supplies rise. It goes low again `CS_GAP_US` microseconds later for the transfer.
- R5: A byte is taken on a cycle where `cfg_valid` and `cfg_ready` are both 1. It is sent most significant bit first, with `mosi` stable at each rising `sclk` and `sclk` idling at 0. `cfg_ready` is 1 only while chip select is low in the transfer phase and no byte is shifting.
- R6: Each high and each low phase of `sclk` lasts at least ceil(`CLK_HZ`/(2·`SPI_MAX_HZ`)) clock cycles. That is 4 cycles at the defaults, so `sclk` stays at or below 25 MHz.
- R7: After the byte flagged by `cfg_last`, exactly `DUMMY_CLKS` (default 49) further rising `sclk` edges occur, all with `mosi` = 1. Chip select then returns high.
- R8: If `cfg_done_in` rises within the timeout after chip select is released, `done` becomes 1 and `error` stays 0.
- R9: If `cfg_done_in` stays low for `TIMEOUT_US` microseconds (default 100) after chip select is released, `error` becomes 1 exactly that many cycles later.
- R10: A start pulse is ignored while `busy` is 1. The supplies are not cycled again and the transfer carries on unchanged. A start is accepted again from DONE or ERROR.
- R11: `busy` is 1 from the accepted start until the outcome. `done` and `error` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| cfg_data | input | 8 | Configuration byte |
| cfg_valid | input | 1 | `cfg_data` holds a byte to send |
| cfg_last | input | 1 | Marks the final byte of the bitstream |
| cfg_ready | output | 1 | The sequencer accepts a byte this cycle |
| cfg_done_in | input | 1 | Configuration-done pin from the target (asynchronous) |
| tgt_rst_n | output | 1 | Active-low reset to the target |
| tgt_cs_n | output | 1 | Active-low SPI chip select to the target |
| vio_en | output | 1 | I/O supply enable |
| vcore_en | output | 1 | Core supply enable |
| sclk | output | 1 | SPI serial clock (mode 0) |
| mosi | output | 1 | SPI serial data to the target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Configuration completed |
| error | output | 1 | Done pin timed out |

## Verification
The assertions assume that `start` is a single-cycle pulse. They also assume that `cfg_done_in` is low from the start until chip select is released after the dummy clocks, so it never reaches the wait phase already high. The stimulus raises the done pin only after chip select goes high following the transfer, and drops it again before the next start. It also changes `cfg_valid`, `cfg_data` and `cfg_last` only on falling clock edges, so the byte is stable across each handshake edge.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_POWER,
      ST_GAP,
      ST_SHIFT,
      ST_DUMMY,
      ST_WAIT,
      ST_DONE,
      ST_ERROR
   } fcl_state_e;

   function automatic int fcl_ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int fcl_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fcl_delay.sv
// Down-counting delay timer: load N-1, zero flags after N cycles in a state.
module fcl_delay #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/fcl_spi_tx.sv
// Mode-0 SPI shifter: sends NBITS bits MSB first, or NBITS ones when fill is set.
module fcl_spi_tx #(
   parameter int HALF = 4,
   parameter int NBW  = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [7:0]     din,
   input  logic [NBW-1:0] nbits,
   input  logic           fill,
   output logic           active,
   output logic           sclk,
   output logic           mosi
);

   logic           act_q;
   logic           sclk_q;
   logic           fill_q;
   logic [7:0]     sh_q;
   logic [NBW-1:0] left_q;
   logic           tick;

   generate
      if (HALF <= 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(HALF);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (load || !act_q || div_q == DW'(HALF - 1))
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         sclk_q <= 1'b0;
         fill_q <= 1'b0;
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         act_q  <= 1'b1;
         sclk_q <= 1'b0;
         fill_q <= fill;
         sh_q   <= din;
         left_q <= nbits;
      end else if (act_q && tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
         end else begin
            sclk_q <= 1'b0;
            sh_q   <= {sh_q[6:0], 1'b0};
            left_q <= left_q - 1'b1;
            if (left_q == NBW'(1))
               act_q <= 1'b0;
         end
      end
   end

   assign active = act_q;
   assign sclk   = sclk_q;
   assign mosi   = act_q && (fill_q || sh_q[7]);

   // Checker: phase length of sclk
   localparam int HW = $clog2(HALF + 2) + 1;
   logic [HW-1:0] hold_q;
   logic          sclk_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         sclk_p <= 1'b0;
      end else begin
         sclk_p <= sclk_q;
         if (sclk_q != sclk_p)
            hold_q <= HW'(1);
         else if (hold_q != {HW{1'b1}})
            hold_q <= hold_q + 1'b1;
      end
   end

   a_r6_sclk_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q != $past(sclk_q)) |-> ($past(hold_q) >= HW'(HALF - 1)));

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
   import fcl_pkg::*;
#(
   parameter int CLK_HZ     = 200_000_000,
   parameter int SPI_MAX_HZ = 25_000_000,
   parameter int CS_LEAD_US = 1,
   parameter int POWER_US   = 50,
   parameter int CS_GAP_US  = 1,
   parameter int TIMEOUT_US = 100,
   parameter int DUMMY_CLKS = 49
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] cfg_data,
   input  logic       cfg_valid,
   input  logic       cfg_last,
   output logic       cfg_ready,
   input  logic       cfg_done_in,
   output logic       tgt_rst_n,
   output logic       tgt_cs_n,
   output logic       vio_en,
   output logic       vcore_en,
   output logic       sclk,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic       error
);

   localparam int CYC_US  = CLK_HZ / 1_000_000;
   localparam int LEAD_C  = fcl_max(1, CS_LEAD_US * CYC_US);
   localparam int POWER_C = fcl_max(1, POWER_US * CYC_US);
   localparam int GAP_C   = fcl_max(1, CS_GAP_US * CYC_US);
   localparam int TO_C    = fcl_max(1, TIMEOUT_US * CYC_US);
   localparam int HALF    = fcl_ceil_div(CLK_HZ, 2 * SPI_MAX_HZ);
   localparam int TMR_MAX = fcl_max(fcl_max(LEAD_C, POWER_C), fcl_max(GAP_C, TO_C));
   localparam int TW      = $clog2(TMR_MAX + 1);
   localparam int NBW     = $clog2(fcl_max(DUMMY_CLKS, 8) + 1);

   generate
      if (CLK_HZ < 1_000_000) begin : g_bad_clk
         $error("fpga_cfg_loader: CLK_HZ must be at least 1 MHz");
      end
      if (SPI_MAX_HZ <= 0) begin : g_bad_spi
         $error("fpga_cfg_loader: SPI_MAX_HZ must be positive");
      end
      if (DUMMY_CLKS < 1) begin : g_bad_dummy
         $error("fpga_cfg_loader: DUMMY_CLKS must be positive");
      end
   endgenerate

   fcl_state_e     st_q, st_d;
   logic [1:0]     dsync_q;
   logic           done_s;
   logic           last_q;
   logic           rst_hold_q;
   logic           tmr_ld;
   logic [TW-1:0]  tmr_val;
   logic           tmr_zero;
   logic           spi_ld;
   logic           spi_fill;
   logic [NBW-1:0] spi_nb;
   logic           spi_act;
   logic           take;
   logic           idle_like;

   assign done_s    = dsync_q[1];
   assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERROR);
   assign cfg_ready = (st_q == ST_SHIFT) && !spi_act && !last_q;
   assign take      = cfg_valid && cfg_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dsync_q <= '0;
      else
         dsync_q <= {dsync_q[0], cfg_done_in};
   end

   always_comb begin
      st_d     = st_q;
      tmr_ld   = 1'b0;
      tmr_val  = '0;
      spi_ld   = 1'b0;
      spi_fill = 1'b0;
      spi_nb   = NBW'(8);
      unique case (st_q)
         ST_IDLE, ST_DONE, ST_ERROR: if (start) begin
            st_d    = ST_SETUP;
            tmr_ld  = 1'b1;
            tmr_val = TW'(LEAD_C - 1);
         end
         ST_SETUP: if (tmr_zero) begin
            st_d    = ST_POWER;
            tmr_ld  = 1'b1;
            tmr_val = TW'(POWER_C - 1);
         end
         ST_POWER: if (tmr_zero) begin
            st_d    = ST_GAP;
            tmr_ld  = 1'b1;
            tmr_val = TW'(GAP_C - 1);
         end
         ST_GAP: if (tmr_zero) st_d = ST_SHIFT;
         ST_SHIFT: begin
            if (take) begin
               spi_ld = 1'b1;
            end else if (last_q && !spi_act) begin
               spi_ld   = 1'b1;
               spi_fill = 1'b1;
               spi_nb   = NBW'(DUMMY_CLKS);
               st_d     = ST_DUMMY;
            end
         end
         ST_DUMMY: if (!spi_act) begin
            st_d    = ST_WAIT;
            tmr_ld  = 1'b1;
            tmr_val = TW'(TO_C - 1);
         end
         ST_WAIT: begin
            if (done_s)
               st_d = ST_DONE;
            else if (tmr_zero)
               st_d = ST_ERROR;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         last_q     <= 1'b0;
         rst_hold_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (idle_like && start) begin
            last_q     <= 1'b0;
            rst_hold_q <= 1'b1;
         end else if (take && cfg_last) begin
            last_q <= 1'b1;
         end
      end
   end

   fcl_delay #(.W(TW)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_ld),
      .val   (tmr_val),
      .zero  (tmr_zero)
   );

   fcl_spi_tx #(.HALF(HALF), .NBW(NBW)) u_spi (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (spi_ld),
      .din    (cfg_data),
      .nbits  (spi_nb),
      .fill   (spi_fill),
      .active (spi_act),
      .sclk   (sclk),
      .mosi   (mosi)
   );

   assign tgt_rst_n = !rst_hold_q;
   assign tgt_cs_n  = !((st_q == ST_SETUP) || (st_q == ST_POWER) ||
                        (st_q == ST_SHIFT) || (st_q == ST_DUMMY));
   assign vio_en    = !((st_q == ST_IDLE) || (st_q == ST_SETUP));
   assign vcore_en  = !((st_q == ST_IDLE) || (st_q == ST_SETUP));
   assign busy      = !idle_like;
   assign done      = (st_q == ST_DONE);
   assign error     = (st_q == ST_ERROR);

   a_r1_reset_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> !tgt_rst_n);

   a_r2_cs_low_at_power: assert property (@(posedge clk) disable iff (!rst_n)
      (vio_en && !$past(vio_en)) |-> (!tgt_cs_n && !$past(tgt_cs_n)));

   a_r3_supplies_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> (vio_en && vcore_en));

   a_r5_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ready |-> (!tgt_cs_n && !spi_act));

   a_r7_dummy_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DUMMY && sclk) |-> mosi);

   a_r9_timeout_error: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && tmr_zero && !done_s) |=> error);

   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && st_q != ST_SETUP) |=> (st_q != ST_SETUP));

   a_r11_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

endmodule

// File: tb/tb_fpga_cfg_loader.sv
`timescale 1ns/1ps
module tb_fpga_cfg_loader;

   localparam int SETUP_C = 200;
   localparam int PWR_C   = 10000;
   localparam int TO_C    = 20000;
   localparam int HALF    = 4;
   localparam int NDUMMY  = 49;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] cfg_data = '0;
   logic       cfg_valid = 1'b0;
   logic       cfg_last = 1'b0;
   logic       cfg_ready;
   logic       cfg_done_in = 1'b0;
   logic       tgt_rst_n, tgt_cs_n, vio_en, vcore_en, sclk, mosi;
   logic       busy, done, error;

   fpga_cfg_loader dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_data(cfg_data),
      .cfg_valid(cfg_valid), .cfg_last(cfg_last), .cfg_ready(cfg_ready),
      .cfg_done_in(cfg_done_in), .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n),
      .vio_en(vio_en), .vcore_en(vcore_en), .sclk(sclk), .mosi(mosi),
      .busy(busy), .done(done), .error(error)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Scoreboard
   logic [7:0] exp_q[$];
   int nb_exp = 0;
   int sup_rises = 0;

   // Monitor
   logic cs_p = 1'b1, sclk_p = 1'b0, sup_p = 1'b0;
   int bits = 0, dummy_bad = 0, run = 0, minrun = 999;
   int t_cs_fall = 0, t_sup = 0;
   logic [7:0] sh = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         cs_p = 1'b1; sclk_p = 1'b0; sup_p = 1'b0;
      end else begin
         if (cs_p && !tgt_cs_n) begin
            t_cs_fall = cyc; bits = 0; dummy_bad = 0; run = 1; minrun = 999;
         end
         if (!sup_p && vio_en) begin
            sup_rises++;
            chk(tgt_cs_n == 1'b0, "R2", "cs low when supplies rise", tgt_cs_n, 0);
            chk(cyc - t_cs_fall == SETUP_C, "R2", "cs lead cycles", cyc - t_cs_fall, SETUP_C);
            chk(vcore_en == 1'b1, "R3", "core supply with io supply", vcore_en, 1);
            t_sup = cyc;
         end
         if (!tgt_cs_n) begin
            if (sclk != sclk_p) begin
               if (run < minrun) minrun = run;
               run = 1;
            end else begin
               run++;
            end
            if (sclk && !sclk_p) begin
               bits++;
               if (bits <= 8 * nb_exp) begin
                  sh = {sh[6:0], mosi};
                  if (bits % 8 == 0) begin
                     if (exp_q.size() == 0)
                        chk(1'b0, "R5", "unexpected byte", sh, -1);
                     else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(sh == e, "R5", "byte MSB first", sh, e);
                     end
                  end
               end else if (!mosi) begin
                  dummy_bad++;
               end
            end
         end
         if (!cs_p && tgt_cs_n) begin
            if (bits == 0) begin
               chk(cyc - t_sup == PWR_C, "R4", "power hold cycles", cyc - t_sup, PWR_C);
            end else begin
               chk(bits == 8 * nb_exp + NDUMMY, "R7", "sclk rising edges", bits, 8 * nb_exp + NDUMMY);
               chk(dummy_bad == 0, "R7", "dummy mosi low count", dummy_bad, 0);
               chk(minrun >= HALF, "R6", "min sclk phase", minrun, HALF);
               chk(exp_q.size() == 0, "R5", "bytes left unsent", exp_q.size(), 0);
            end
         end
         cs_p = tgt_cs_n; sclk_p = sclk; sup_p = vio_en;
      end
   end

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit last);
      cfg_data = b; cfg_last = last; cfg_valid = 1'b1;
      while (!cfg_ready) @(negedge clk);
      @(negedge clk);
      exp_q.push_back(b);
      cfg_valid = 1'b0; cfg_last = 1'b0;
   endtask

   task automatic run_load(input logic [7:0] data[$], input int gap,
                           input bit respond, input int resp_delay, input bit poke);
      int base, t0, w;
      nb_exp = data.size();
      base = sup_rises;
      @(negedge clk);
      pulse_start();
      chk(tgt_rst_n == 1'b0, "R1", "target reset after start", tgt_rst_n, 0);
      chk(busy == 1'b1, "R11", "busy after start", busy, 1);
      foreach (data[i]) begin
         send_byte(data[i], i == data.size() - 1);
         if (poke && i == 0) pulse_start();   // R10: ignored while busy
         repeat (gap) @(negedge clk);
      end
      while (tgt_cs_n !== 1'b1) @(negedge clk);
      t0 = cyc;
      if (respond) begin
         repeat (resp_delay / 2) @(negedge clk);
         if (poke) pulse_start();
         repeat (resp_delay - resp_delay / 2) @(negedge clk);
         cfg_done_in = 1'b1;
         w = 0;
         while (!done && w < 20) begin @(negedge clk); w++; end
         chk(done == 1'b1, "R8", "done after done pin", done, 1);
         chk(error == 1'b0, "R11", "no error with done", error, 0);
         chk(tgt_rst_n == 1'b0, "R1", "reset held in DONE", tgt_rst_n, 0);
         chk(vio_en && vcore_en, "R3", "supplies on in DONE", vio_en && vcore_en, 1);
         cfg_done_in = 1'b0;
      end else begin
         w = 0;
         while (!error && w < TO_C + 50) begin @(negedge clk); w++; end
         chk(cyc - t0 == TO_C, "R9", "timeout cycles", cyc - t0, TO_C);
         chk(done == 1'b0, "R11", "no done with error", done, 0);
         chk(tgt_rst_n == 1'b0, "R1", "reset held in ERROR", tgt_rst_n, 0);
         chk(busy == 1'b0, "R11", "busy cleared", busy, 0);
      end
      chk(sup_rises - base == 1, "R10", "supply power-ups this run", sup_rises - base, 1);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] a[$], b[$], c[$];
      a = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
      b = '{8'h81};
      c = '{8'h00, 8'h7E, 8'hC3};
      repeat (5) @(negedge clk);
      // R1 / R11 reset state
      chk(tgt_rst_n == 1'b1, "R1", "reset state tgt_rst_n", tgt_rst_n, 1);
      chk(tgt_cs_n == 1'b1, "R2", "reset state cs", tgt_cs_n, 1);
      chk(!vio_en && !vcore_en, "R3", "reset state supplies", vio_en || vcore_en, 0);
      chk(sclk == 1'b0, "R5", "reset state sclk", sclk, 0);
      chk(cfg_ready == 1'b0, "R5", "reset state ready", cfg_ready, 0);
      chk(!busy && !done && !error, "R11", "reset state status", busy + done + error, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run_load(a, 5, 1'b1, 300, 1'b1);   // gaps, start pokes
      run_load(b, 0, 1'b0, 0, 1'b0);     // R9 timeout, restart from DONE
      run_load(c, 0, 1'b1, 0, 1'b0);     // R10 restart from ERROR, back to back
      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule